// File: doc/BRIEF.md
# Receive Descriptor Ring Index Controller

This block keeps the device-side indices for one receive descriptor ring that lives in host memory. The host posts empty buffers by writing a ring index that points one slot past the last buffer it has prepared. The device keeps its own fill index, which moves forward each time a buffer is closed. The block compares the two indices and decides whether another slot may be consumed. For every closed buffer it raises a status-write request that carries the index of that buffer. It also raises a host interrupt once a programmable quiet period has passed after the most recent close.

A configuration port sets four things: the ring size as a power-of-two exponent, the channel run mode, the interrupt target and the timeout. The run mode can be stopped, stop-after-frame or running. The timeout is counted in 32 µs units, taken from a clock prescaler. An idle flag tells the host when the channel has come to rest after it was disabled.

Buffer closes arrive on a valid/ready stream (`close_valid`/`close_ready`). A close is taken only in a cycle where both are high, and the producer must hold `close_valid` until then. Status requests leave on a second valid/ready stream (`stat_valid`/`stat_ready`). Back-pressure on that stream never stalls closes. While a request waits, a newer close replaces the carried index, so the request always reports the most recent buffer filled.

Top module: `rri_ring_ctrl`

## Requirements
- R1: After reset, `close_ready`, `stat_valid` and `irq` are 0 and `idle` is 1. The configuration resets to mode stopped, exponent 8, no interrupt target and timeout 16.
- R2: `cfg_ring_log` gives the ring size as 2^N. Values below 5 act as 5 and values above 12 act as 12. The fill index wraps to 0 after slot 2^N−1.
- R3: The three least significant bits of the host write index are ignored. Only the index rounded down to a multiple of 8, taken modulo the ring size, marks the end of available slots.
- R4: When the fill index equals the aligned host write index, `close_ready` is 0. Slots become available again only after the host write index moves.
- R5: An accepted close makes `stat_valid` 1 on the next cycle. `stat_index` then carries the 12-bit index of the slot just closed, and the fill index advances by one.
- R6: While `stat_valid` is 1 and `stat_ready` is 0, the request and its index stay unchanged unless a new close is accepted. A new close replaces the index and keeps the request valid, and this also holds in a cycle where `stat_ready` is 1.
- R7: Mode code 00 (stopped) drops `close_ready` to 0 immediately. `idle` is 1 whenever the channel accepts no closes and no status request is pending.
- R8: Mode code 01 (stop after frame) keeps accepting closes only while a frame is open. A frame is open after a close with `close_eof`=0 and closed by a close with `close_eof`=1. With no open frame, the channel stops at once.
- R9: Mode code 10 runs normally. Mode code 11 behaves as stopped.
- R10: With interrupt target code 01, `irq` is a single-cycle pulse exactly T×TICK_DIV cycles after the most recent accepted close, where T is `cfg_tmo` and a value of 0 counts as 1. Every accepted close restarts this wait.
- R11: With any interrupt target code other than 01, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Loads all configuration fields |
| cfg_en | input | 2 | Run mode: 00 stopped, 01 stop after frame, 10 running, 11 stopped |
| cfg_ring_log | input | 4 | Ring size exponent N |
| cfg_irq_sel | input | 2 | Interrupt target: 01 host, others none |
| cfg_tmo | input | 8 | Timeout in prescaler ticks |
| host_we | input | 1 | Loads the host write index |
| host_widx | input | 12 | Host write index, one past the last posted buffer |
| close_valid | input | 1 | A filled buffer is ready to close |
| close_eof | input | 1 | The closing buffer ends a frame |
| close_ready | output | 1 | A slot may be consumed this cycle |
| stat_valid | output | 1 | Status write request pending |
| stat_ready | input | 1 | Status write request taken |
| stat_index | output | 12 | Index of the most recently filled slot |
| irq | output | 1 | Timeout interrupt pulse |
| idle | output | 1 | Channel stopped with nothing pending |

## Verification
A close can be accepted in the same cycle that the status stream hands off its pending request. In that cycle the status port must keep `stat_valid` high and take the newer index, rather than clear the request. The bench provokes this by raising `stat_ready` and `close_valid` on the same cycle after holding a request back. It then expects the new index to remain valid for one more cycle before the request clears. A second overlap, a close arriving while the timeout wait is running, is provoked partway through a wait. It is judged by the pulse landing a full timeout after the later close and never after the earlier one.

// File: rtl/rri_pkg.sv
package rri_pkg;
  typedef enum logic [1:0] {
    EN_OFF = 2'b00,
    EN_EOF = 2'b01,
    EN_RUN = 2'b10,
    EN_RSV = 2'b11
  } en_mode_e;

  localparam logic [1:0] IRQ_TO_HOST = 2'b01;
endpackage

// File: rtl/rri_fill_track.sv
module rri_fill_track
  import rri_pkg::*;
#(
  parameter int IDX_W     = 12,
  parameter int LOG_W     = 4,
  parameter int MIN_LOG   = 5,
  parameter int ALIGN_LOG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOG_W-1:0] ring_log,
  input  en_mode_e         mode,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_widx,
  input  logic             close_valid,
  input  logic             close_eof,
  output logic             close_ready,
  output logic             accept,
  output logic             gate_open,
  output logic [IDX_W-1:0] fill_idx,
  output logic [IDX_W-1:0] ring_mask
);
  localparam logic [IDX_W-1:0] ALIGN_MASK =
    ~((IDX_W'(1) << ALIGN_LOG) - IDX_W'(1));

  logic [IDX_W-1:0] wptr_q, fill_q, avail_end;
  logic             frame_open_q;
  int               eff_log;

  always_comb begin
    if (int'(ring_log) < MIN_LOG)    eff_log = MIN_LOG;
    else if (int'(ring_log) > IDX_W) eff_log = IDX_W;
    else                             eff_log = int'(ring_log);
  end

  for (genvar g = 0; g < IDX_W; g++) begin : g_mask
    assign ring_mask[g] = (g < eff_log);
  end

  assign fill_idx  = fill_q & ring_mask;
  assign avail_end = wptr_q & ALIGN_MASK & ring_mask;
  assign gate_open = (mode == EN_RUN) || ((mode == EN_EOF) && frame_open_q);
  assign close_ready = gate_open && (fill_idx != avail_end);
  assign accept      = close_valid && close_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q       <= '0;
      fill_q       <= '0;
      frame_open_q <= 1'b0;
    end else begin
      if (host_we) wptr_q <= host_widx;
      if (accept) begin
        fill_q       <= (fill_idx + IDX_W'(1)) & ring_mask;
        frame_open_q <= !close_eof;
      end
    end
  end
endmodule

// File: rtl/rri_stat_port.sv
module rri_stat_port #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [IDX_W-1:0] closed_idx,
  input  logic             stat_ready,
  output logic             stat_valid,
  output logic [IDX_W-1:0] stat_index
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_index <= '0;
    end else if (accept) begin
      stat_valid <= 1'b1;
      stat_index <= closed_idx;
    end else if (stat_ready) begin
      stat_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rri_irq_timer.sv
module rri_irq_timer #(
  parameter int TICK_DIV = 8000,
  parameter int TMO_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [TMO_W-1:0] tmo,
  input  logic             to_host,
  output logic             irq
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0]    pre_q;
  logic [TMO_W-1:0] cnt_q, tmo_eff;
  logic             armed_q, tick;

  assign tick    = (pre_q == PRE_LAST);
  assign tmo_eff = (tmo == '0) ? TMO_W'(1) : tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (restart) begin
        pre_q   <= '0;
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else begin
        pre_q <= tick ? '0 : pre_q + PW'(1);
        if (tick && armed_q) begin
          if (({1'b0, cnt_q} + 1'b1) >= {1'b0, tmo_eff}) begin
            armed_q <= 1'b0;
            irq     <= to_host;
          end else begin
            cnt_q <= cnt_q + TMO_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/rri_ring_ctrl.sv
module rri_ring_ctrl
  import rri_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int LOG_W    = 4,
  parameter int TMO_W    = 8,
  parameter int TICK_DIV = 8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_en,
  input  logic [LOG_W-1:0] cfg_ring_log,
  input  logic [1:0]       cfg_irq_sel,
  input  logic [TMO_W-1:0] cfg_tmo,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_widx,
  input  logic             close_valid,
  input  logic             close_eof,
  output logic             close_ready,
  output logic             stat_valid,
  input  logic             stat_ready,
  output logic [IDX_W-1:0] stat_index,
  output logic             irq,
  output logic             idle
);
  localparam logic [LOG_W-1:0] RST_LOG = LOG_W'(8);
  localparam logic [TMO_W-1:0] RST_TMO = TMO_W'(16);

  en_mode_e         mode_q;
  logic [LOG_W-1:0] log_q;
  logic [1:0]       sel_q;
  logic [TMO_W-1:0] tmo_q;
  logic             accept, gate_open;
  logic [IDX_W-1:0] fill_idx, ring_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= EN_OFF;
      log_q  <= RST_LOG;
      sel_q  <= 2'b00;
      tmo_q  <= RST_TMO;
    end else if (cfg_we) begin
      mode_q <= en_mode_e'(cfg_en);
      log_q  <= cfg_ring_log;
      sel_q  <= cfg_irq_sel;
      tmo_q  <= cfg_tmo;
    end
  end

  rri_fill_track #(.IDX_W(IDX_W), .LOG_W(LOG_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .ring_log(log_q), .mode(mode_q),
    .host_we(host_we), .host_widx(host_widx),
    .close_valid(close_valid), .close_eof(close_eof),
    .close_ready(close_ready), .accept(accept), .gate_open(gate_open),
    .fill_idx(fill_idx), .ring_mask(ring_mask)
  );

  rri_stat_port #(.IDX_W(IDX_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .accept(accept), .closed_idx(fill_idx),
    .stat_ready(stat_ready), .stat_valid(stat_valid), .stat_index(stat_index)
  );

  rri_irq_timer #(.TICK_DIV(TICK_DIV), .TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(accept), .tmo(tmo_q),
    .to_host(sel_q == IRQ_TO_HOST), .irq(irq)
  );

  assign idle = !gate_open && !stat_valid;
endmodule

// File: rtl/rri_ring_ctrl_chk.sv
module rri_ring_ctrl_chk
  import rri_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input en_mode_e         mode_q,
  input logic [1:0]       sel_q,
  input logic             accept,
  input logic [IDX_W-1:0] fill_idx,
  input logic [IDX_W-1:0] ring_mask,
  input logic             close_ready,
  input logic             stat_valid,
  input logic             stat_ready,
  input logic [IDX_W-1:0] stat_index,
  input logic             irq,
  input logic             idle
);
  AST_FILL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cfg_we |=> fill_idx == (($past(fill_idx) + IDX_W'(1)) & $past(ring_mask))); // R2
  AST_STAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> stat_valid && (stat_index == $past(fill_idx))); // R5
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !stat_ready && !accept |=> stat_valid && $stable(stat_index)); // R6
  AST_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == EN_OFF) || (mode_q == EN_RSV) |-> !close_ready); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !close_ready && !stat_valid); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10
  AST_IRQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sel_q) == IRQ_TO_HOST); // R11
endmodule

bind rri_ring_ctrl rri_ring_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mode_q(mode_q), .sel_q(sel_q),
  .accept(accept), .fill_idx(fill_idx), .ring_mask(ring_mask),
  .close_ready(close_ready), .stat_valid(stat_valid), .stat_ready(stat_ready),
  .stat_index(stat_index), .irq(irq), .idle(idle)
);

// File: tb/rri_ring_ctrl_tb.sv
`timescale 1ns/1ps
module rri_ring_ctrl_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_en = 2'b00;
  logic [3:0]  cfg_ring_log = 4'd8;
  logic [1:0]  cfg_irq_sel = 2'b00;
  logic [7:0]  cfg_tmo = 8'd16;
  logic        host_we = 1'b0;
  logic [11:0] host_widx = '0;
  logic        close_valid = 1'b0;
  logic        close_eof = 1'b0;
  logic        close_ready, stat_valid, irq, idle;
  logic        stat_ready = 1'b1;
  logic [11:0] stat_index;

  int tests = 0;
  int failed = 0;
  int f_m = 0;

  always #2 clk = ~clk;

  rri_ring_ctrl #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_ring_log(cfg_ring_log), .cfg_irq_sel(cfg_irq_sel), .cfg_tmo(cfg_tmo),
    .host_we(host_we), .host_widx(host_widx), .close_valid(close_valid),
    .close_eof(close_eof), .close_ready(close_ready), .stat_valid(stat_valid),
    .stat_ready(stat_ready), .stat_index(stat_index), .irq(irq), .idle(idle)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] en, input logic [3:0] lg,
                         input logic [1:0] sel, input logic [7:0] tmo);
    cfg_en = en; cfg_ring_log = lg; cfg_irq_sel = sel; cfg_tmo = tmo;
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic host_write(input int w);
    host_widx = 12'(w);
    host_we = 1'b1;
    step();
    host_we = 1'b0;
  endtask

  // Close one buffer; R5: status request carries the closed slot index.
  task automatic close_one(input logic eof, input int size);
    chk("R4 slot available before close", int'(close_ready), 1);
    close_valid = 1'b1;
    close_eof = eof;
    step();
    close_valid = 1'b0;
    chk("R5 stat_valid after close", int'(stat_valid), 1);
    chk("R5 stat_index", int'(stat_index), f_m);
    f_m = (f_m + 1) % size;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    int size;
    int nirq;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 close_ready", int'(close_ready), 0);
    chk("R1 stat_valid", int'(stat_valid), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 idle", int'(idle), 1);
    rst_n = 1'b1;
    step();
    chk("R1 idle after release", int'(idle), 1);

    // Sweep two ring sizes through two full wraps each.
    for (int n = 5; n <= 6; n++) begin
      size = 1 << n;
      set_cfg(2'b10, 4'(n), 2'b00, 8'd16);
      chk("R4 equal indices no room", int'(close_ready), 0);
      for (int r = 0; r < 2 * size / 8; r++) begin
        host_write(((f_m + 8) % size) | (r % 8));   // R3 low bits vary
        for (int k = 0; k < 8; k++) close_one(1'b1, size);
        chk("R3 R4 stall at aligned write index", int'(close_ready), 0);
      end
    end

    // R2 clamp: exponent 2 behaves as 32 entries
    set_cfg(2'b10, 4'd2, 2'b00, 8'd16);
    host_write(27);
    for (int k = 0; k < 24; k++) close_one(1'b1, 32);
    host_write(5);
    for (int k = 0; k < 8; k++) close_one(1'b1, 32);
    chk("R2 wrap at 32 for clamped exponent", int'(close_ready), 0);
    chk("R2 index back to zero", f_m, 0);

    set_cfg(2'b10, 4'd5, 2'b00, 8'd16);
    host_write(16);

    // R6 hold and coalesce under back-pressure
    stat_ready = 1'b0;
    close_one(1'b1, 32);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R6 held valid", int'(stat_valid), 1);
      chk("R6 held index", int'(stat_index), 0);
    end
    close_one(1'b1, 32);
    // same-cycle handoff and new close
    stat_ready = 1'b1;
    close_valid = 1'b1;
    close_eof = 1'b1;
    step();
    close_valid = 1'b0;
    chk("R6 collision keeps valid", int'(stat_valid), 1);
    chk("R6 collision new index", int'(stat_index), 2);
    f_m = 3;
    step();
    chk("R6 request clears", int'(stat_valid), 0);

    // R7 stopped mode
    stat_ready = 1'b0;
    close_one(1'b1, 32);
    set_cfg(2'b00, 4'd5, 2'b00, 8'd16);
    chk("R7 stopped no ready", int'(close_ready), 0);
    chk("R7 not idle while status pending", int'(idle), 0);
    stat_ready = 1'b1;
    step();
    chk("R7 idle once drained", int'(idle), 1);

    // R9 reserved code stops
    set_cfg(2'b11, 4'd5, 2'b00, 8'd16);
    chk("R9 code 11 no ready", int'(close_ready), 0);
    chk("R9 code 11 idle", int'(idle), 1);

    // R8 stop after frame
    set_cfg(2'b10, 4'd5, 2'b00, 8'd16);
    close_one(1'b0, 32);
    set_cfg(2'b01, 4'd5, 2'b00, 8'd16);
    chk("R8 open frame keeps ready", int'(close_ready), 1);
    close_one(1'b0, 32);
    close_one(1'b1, 32);
    chk("R8 stops after frame end", int'(close_ready), 0);
    step();
    chk("R8 idle after frame end", int'(idle), 1);
    set_cfg(2'b00, 4'd5, 2'b00, 8'd16);
    set_cfg(2'b01, 4'd5, 2'b00, 8'd16);
    chk("R8 no open frame stops at once", int'(close_ready), 0);

    // R10 timeout interrupt, T=3 -> 12 cycles
    set_cfg(2'b10, 4'd5, 2'b01, 8'd3);
    close_one(1'b1, 32);
    nirq = 0;
    for (int k = 1; k < 3 * DIV; k++) begin step(); nirq += int'(irq); end
    chk("R10 no early irq", nirq, 0);
    step();
    chk("R10 irq at timeout", int'(irq), 1);
    step();
    chk("R10 single-cycle pulse", int'(irq), 0);
    // restart by a later close
    close_one(1'b1, 32);
    nirq = 0;
    for (int k = 0; k < 6; k++) begin step(); nirq += int'(irq); end
    close_one(1'b1, 32);
    for (int k = 1; k < 3 * DIV; k++) begin step(); nirq += int'(irq); end
    chk("R10 restart suppresses earlier deadline", nirq, 0);
    step();
    chk("R10 irq after restarted wait", int'(irq), 1);
    // T=0 counts as 1
    set_cfg(2'b10, 4'd5, 2'b01, 8'd0);
    close_one(1'b1, 32);
    nirq = 0;
    for (int k = 1; k < DIV; k++) begin step(); nirq += int'(irq); end
    chk("R10 zero timeout no early irq", nirq, 0);
    step();
    chk("R10 zero timeout fires after one tick", int'(irq), 1);

    // R11 no target
    set_cfg(2'b10, 4'd5, 2'b00, 8'd1);
    close_one(1'b1, 32);
    nirq = 0;
    for (int k = 0; k < 20; k++) begin step(); nirq += int'(irq); end
    chk("R11 no irq without host target", nirq, 0);
    set_cfg(2'b10, 4'd5, 2'b10, 8'd1);
    close_one(1'b1, 32);
    nirq = 0;
    for (int k = 0; k < 20; k++) begin step(); nirq += int'(irq); end
    chk("R11 no irq for code 10", nirq, 0);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule